// File: doc/BRIEF.md
# Hop Channel Selector Kernel

The block turns a 5-bit phase value, a one-bit permutation modifier, a one-bit offset flag and a 28-bit device address into a radio channel number in the range 0 to 78. The mapping runs through a fixed chain of stages:

- a modulo-32 add;
- a bitwise XOR on the low four bits;
- fourteen conditional bit swaps steered by address bits and the modifier;
- a modulo-79 add of an address-derived weight and the optional offset of 32;
- a final map that places the first forty indices on even channels and the rest on odd channels.

A request is taken on a valid/ready handshake. The answer appears two clock cycles later on a registered output with its own valid. A downstream stall holds the output and freezes the pipeline. The usual address for the inquiry case is the value 0x9E8B33 in the low 24 bits with a zero upper nibble. The package exports this value as `HS_INQ_ADDR`.

The pipeline has two registered steps. The first step holds the permuted 5-bit value together with the address weight and the offset flag. The second step holds the mapped channel.

Top module: `hopsel_core`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Step one adds address bits 27..23, as an unsigned 5-bit number, to `in_x` modulo 32.
- R3: Step two XORs bits 3..0 of that sum with address bits 22..19 (bit 0 with bit 19). Bit 4 passes unchanged.
- R4: Swap control k for k = 0..8 is address bit 10+k. Controls 9..13 are address bits 0, 2, 4, 6 and 8 respectively, each XORed with `in_y1`.
- R5: The swaps are applied in this order, each exchanging the two listed bit positions when its control is 1: c13(1,2), c12(0,3), c11(1,3), c10(2,4), c9(0,3), c8(1,4), c7(3,4), c6(0,2), c5(1,3), c4(0,4), c3(3,4), c2(1,2), c1(2,3), c0(0,1).
- R6: The index is (permuted value + E + 32·`in_y2`) mod 79. E is the 7-bit number whose bit i is address bit 2i+1, for i = 0..6.
- R7: An index below 40 gives channel 2·index. Any other index gives channel 2·(index−40)+1. The channel never exceeds 78.
- R8: A request accepted at a rising edge is on the output, with `out_valid` high, after the second rising edge that follows. It is not visible after the first.
- R9: While `out_valid` is 1 and `out_ready` is 0, the following hold: `out_chan` and `out_valid` stay unchanged, and `in_ready` is 0.
- R10: A request is taken only when `in_valid` and `in_ready` are both 1. A request presented while `in_ready` is 0, or with `in_valid` low, produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_x | input | 5 | Phase value |
| in_y1 | input | 1 | Permutation modifier |
| in_y2 | input | 1 | Adds 32 to the index sum when 1 |
| in_addr | input | 28 | Device address |
| out_valid | output | 1 | Channel result present |
| out_ready | input | 1 | Consumer takes the result |
| out_chan | output | 7 | Channel number 0..78 |

## Verification
Two events can coincide in one cycle: a result held on the output by a stalled consumer, and a new request offered at the input. The bench provokes this by keeping `out_ready` low after a result arrives and raising `in_valid` with different data. It judges the outcome in three ways:

- The held channel must not change while the stall lasts.
- `in_ready` must stay low during the stall.
- The offered request must leave no trace: after the stall is released, the next cycle shows no valid output.

The channel values themselves are checked by sweeping every phase, modifier and offset combination over several addresses, against an arithmetic model written in the bench.

// File: rtl/hopsel_pkg.sv
package hopsel_pkg;

    localparam int HS_XW   = 5;
    localparam int HS_AW   = 28;
    localparam int HS_EW   = 7;
    localparam int HS_CW   = 7;
    localparam int HS_NSW  = 14;
    localparam int HS_MOD  = 79;
    localparam int HS_HALF = 40;

    localparam logic [HS_AW-1:0] HS_INQ_ADDR = 28'h09E8B33;

    // swap stage j (applied j-th) exchanges these bit positions
    function automatic int swap_lo(input int j);
        case (j)
            0: return 1;  1: return 0;  2: return 1;  3: return 2;
            4: return 0;  5: return 1;  6: return 3;  7: return 0;
            8: return 1;  9: return 0;  10: return 3; 11: return 1;
            12: return 2; default: return 0;
        endcase
    endfunction

    function automatic int swap_hi(input int j);
        case (j)
            0: return 2;  1: return 3;  2: return 3;  3: return 4;
            4: return 3;  5: return 4;  6: return 4;  7: return 2;
            8: return 3;  9: return 4;  10: return 4; 11: return 2;
            12: return 3; default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/hopsel_mix.sv
module hopsel_mix
    import hopsel_pkg::*;
(
    input  logic [HS_XW-1:0] x,
    input  logic             y1,
    input  logic [HS_AW-1:0] addr,
    output logic [HS_XW-1:0] perm
);
    localparam int NCTL = HS_NSW;

    logic [HS_XW-1:0]           summed;
    logic [HS_XW-1:0]           mixed;
    logic [NCTL-1:0]            ctl;
    logic [NCTL:0][HS_XW-1:0]   st;

    // R2: add of upper address bits modulo 32
    assign summed = x + addr[HS_AW-1 -: HS_XW];
    // R3: XOR of low four bits, bit 4 untouched
    assign mixed  = {summed[4], summed[3:0] ^ addr[22:19]};

    // R4: swap controls
    generate
        for (genvar k = 0; k < 9; k++) begin : g_ctl_lo
            assign ctl[k] = addr[10 + k];
        end
        for (genvar k = 0; k < 5; k++) begin : g_ctl_hi
            assign ctl[9 + k] = addr[2 * k] ^ y1;
        end
    endgenerate

    assign st[0] = mixed;

    // R5: ordered conditional swaps, stage j steered by control 13-j
    generate
        for (genvar j = 0; j < NCTL; j++) begin : g_swap
            localparam int LO = swap_lo(j);
            localparam int HI = swap_hi(j);
            logic [HS_XW-1:0] swapped;
            always_comb begin
                swapped     = st[j];
                swapped[LO] = st[j][HI];
                swapped[HI] = st[j][LO];
            end
            assign st[j+1] = ctl[NCTL-1-j] ? swapped : st[j];
        end
    endgenerate

    assign perm = st[NCTL];

    always_comb begin
        p_perm_ones_r5: assert ($countones(st[NCTL]) == $countones(st[0]));
    end
endmodule

// File: rtl/hopsel_chan.sv
module hopsel_chan
    import hopsel_pkg::*;
(
    input  logic [HS_XW-1:0] perm,
    input  logic [HS_EW-1:0] e,
    input  logic             y2,
    output logic [HS_CW-1:0] chan
);
    localparam int SW = 8;

    logic [SW-1:0] sum;
    logic [SW-1:0] red1;
    logic [SW-1:0] idx;

    // R6: sum is at most 31+127+32 = 190, two conditional subtractions suffice
    assign sum  = SW'(perm) + SW'(e) + (y2 ? SW'(32) : SW'(0));
    assign red1 = (sum  >= SW'(HS_MOD)) ? sum  - SW'(HS_MOD) : sum;
    assign idx  = (red1 >= SW'(HS_MOD)) ? red1 - SW'(HS_MOD) : red1;

    // R7: even channels first, odd channels after
    always_comb begin
        if (idx < SW'(HS_HALF))
            chan = HS_CW'({idx[SW-2:0], 1'b0});
        else
            chan = HS_CW'({idx[SW-2:0] - 7'(HS_HALF), 1'b1});
    end

    always_comb begin
        p_idx_range_r6: assert (idx < SW'(HS_MOD));
        p_even_low_r7:  assert ((idx >= SW'(HS_HALF)) || !chan[0]);
    end
endmodule

// File: rtl/hopsel_core.sv
module hopsel_core
    import hopsel_pkg::*;
#(
    parameter int AW = HS_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [4:0]    in_x,
    input  logic          in_y1,
    input  logic          in_y2,
    input  logic [AW-1:0] in_addr,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [6:0]    out_chan
);
    logic [HS_XW-1:0] perm_c;
    logic [HS_EW-1:0] e_c;
    logic [HS_CW-1:0] chan_c;
    logic             adv;

    logic             a_valid;
    logic [HS_XW-1:0] a_perm;
    logic [HS_EW-1:0] a_e;
    logic             a_y2;

    hopsel_mix u_mix (
        .x    (in_x),
        .y1   (in_y1),
        .addr (HS_AW'(in_addr)),
        .perm (perm_c)
    );

    generate
        for (genvar i = 0; i < HS_EW; i++) begin : g_e
            assign e_c[i] = in_addr[2 * i + 1];
        end
    endgenerate

    hopsel_chan u_chan (
        .perm (a_perm),
        .e    (a_e),
        .y2   (a_y2),
        .chan (chan_c)
    );

    // R9/R10: whole pipeline advances unless a result is held
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_valid   <= 1'b0;
            out_valid <= 1'b0;
        end else if (adv) begin
            a_valid   <= in_valid;
            out_valid <= a_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            a_perm   <= perm_c;
            a_e      <= e_c;
            a_y2     <= in_y2;
            out_chan <= chan_c;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_chan)));

    p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan <= 7'd78));

    p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !a_valid) |=> !out_valid);
endmodule

// File: tb/hopsel_core_test.sv
`timescale 1ns/1ps
module hopsel_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [4:0]  in_x;
    logic        in_y1;
    logic        in_y2;
    logic [27:0] in_addr;
    logic        out_valid;
    logic        out_ready;
    logic [6:0]  out_chan;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    hopsel_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y1(in_y1), .in_y2(in_y2), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan)
    );

    function automatic int model(input int x, input int y1, input int y2, input logic [27:0] a);
        int v, e, idx;
        int lo [14] = '{1,0,1,2,0,1,3,0,1,0,3,1,2,0};
        int hi [14] = '{2,3,3,4,3,4,4,2,3,4,4,2,3,1};
        int c [14];
        logic [4:0] b;
        v = (x + int'(a[27:23])) % 32;
        v = v ^ int'(a[22:19]);
        for (int k = 0; k < 9; k++) c[k] = int'(a[10+k]);
        for (int k = 0; k < 5; k++) c[9+k] = int'(a[2*k]) ^ y1;
        b = v[4:0];
        for (int j = 0; j < 14; j++) begin
            if (c[13-j] != 0) begin
                logic t;
                t = b[lo[j]];
                b[lo[j]] = b[hi[j]];
                b[hi[j]] = t;
            end
        end
        e = 0;
        for (int i = 0; i < 7; i++) e += int'(a[2*i+1]) << i;
        idx = (int'(b) + e + 32 * y2) % 79;
        return (idx < 40) ? 2 * idx : 2 * (idx - 40) + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_one(input int x, input int y1, input int y2, input logic [27:0] a);
        int exp;
        exp = model(x, y1, y2, a);
        in_x = x[4:0]; in_y1 = y1[0]; in_y2 = y2[0]; in_addr = a;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R8 early", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R8 valid", int'(out_valid), 1);
        chk(int'(out_chan) == exp, "R2/R3/R4/R5/R6/R7 chan", int'(out_chan), exp);
        @(negedge clk);
    endtask

    initial begin
        logic [27:0] addrs [6];
        int held;
        addrs[0] = 28'h09E8B33;
        addrs[1] = 28'hFFFFFFF;
        addrs[2] = 28'h0000000;
        addrs[3] = 28'hA5A5A5A;
        addrs[4] = 28'h5555555;
        addrs[5] = 28'h3C7E1D2;
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_x = '0; in_y1 = 1'b0; in_y2 = 1'b0; in_addr = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: no request, no output
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 idle", int'(out_valid), 0);

        for (int ai = 0; ai < 6; ai++)
            for (int x = 0; x < 32; x++)
                for (int y1 = 0; y1 < 2; y1++)
                    for (int y2 = 0; y2 < 2; y2++)
                        run_one(x, y1, y2, addrs[ai]);

        // R9: stall with a competing request
        out_ready = 1'b0;
        in_x = 5'd7; in_y1 = 1'b1; in_y2 = 1'b1; in_addr = addrs[3];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        held = model(7, 1, 1, addrs[3]);
        chk(out_valid == 1'b1, "R9 valid", int'(out_valid), 1);
        chk(int'(out_chan) == held, "R9 chan", int'(out_chan), held);
        in_x = 5'd20; in_y1 = 1'b0; in_y2 = 1'b0; in_addr = addrs[5];
        in_valid = 1'b1;
        for (int s = 0; s < 4; s++) begin
            chk(in_ready == 1'b0, "R9 ready low", int'(in_ready), 0);
            @(negedge clk);
            chk(out_valid == 1'b1 && int'(out_chan) == held, "R9 hold", int'(out_chan), held);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 stalled request dropped", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 still empty", int'(out_valid), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule